// File: doc/BRIEF.md
# I2C Byte Master with Clock-Stretch Timeout

This block is a single-master I2C controller that works one bus event at a time. A host presents an opcode together with a data byte and an acknowledge choice. The controller then produces a START (also used as a repeated START), a STOP, an 8-bit transmit with acknowledge sampling, or an 8-bit receive that ends with an ACK or a NACK. It never drives either line high. It only asserts open-drain pull-down enables and reads the wired bus levels back. Each step of a bus event is held for a programmable number of system clocks, and that count is captured when the command is accepted.

After SCL is released in a data bit, the controller waits until SCL actually reads high, so a slow target can stretch the clock. This wait is bounded. If SCL is still low after `POLL_MAX` consecutive polls, a sticky skip flag is set and later waits are not performed. The flag clears the next time a wait finds SCL high. A transmitted byte that is not acknowledged makes the controller append a STOP on its own, and then report completion with the nack flag set. A host reads a target register by chaining START, WRITE (address, write direction), WRITE (register number), START, WRITE (address, read direction), READ with NACK, and STOP.

Top module: `i2c_byte_master`

## Requirements
- R1: After synchronous reset both pull-down enables are off, and `busy`, `done`, `nack` and `stretch_skip` are 0.
- R2: A command is accepted only in a cycle where `busy` is 0, `cmd_valid` is 1 and `cmd_op` is one of 1 (START), 2 (STOP), 3 (WRITE) or 4 (READ). Other opcodes, and any command presented while `busy` is 1, are ignored: no bus activity, no `busy` and no `done`.
- R3: START releases both lines, then pulls SDA low while SCL stays released, then pulls SCL low. Each step lasts `bit_div`+1 clocks, so `busy` stays high for 3·(`bit_div`+1) clocks. A START issued after a byte, with SCL low, produces a repeated START condition on the bus.
- R4: STOP pulls both lines low, then releases SCL, then releases SDA. Each step lasts `bit_div`+1 clocks, so `busy` stays high for 3·(`bit_div`+1) clocks. The bus ends with both lines released.
- R5: WRITE shifts `cmd_data` out MSB first as 8 data slots and then 1 acknowledge slot. In each slot SDA is set while SCL is pulled low, SCL is released, the controller waits for SCL high, and SCL is pulled low again. Without stretching, `busy` lasts 9·(3·`bit_div`+4) clocks. `done` is a one-cycle pulse in the first cycle with `busy` at 0.
- R6: If the acknowledge slot of a WRITE reads SDA high, the controller runs the STOP sequence and then pulses `done` with `nack` at 1. `busy` lasts 9·(3·`bit_div`+4)+3·(`bit_div`+1) clocks. `nack` holds until the next accepted command clears it.
- R7: READ releases SDA for 8 slots and assembles the sampled bits MSB first into `rd_data`. In the 9th slot it pulls SDA low (ACK) when `cmd_nack` is 0 and leaves SDA released (NACK) when `cmd_nack` is 1.
- R8: While a target holds SCL low after the controller released it, the controller keeps SCL released, and the slot completes once SCL reads high. `stretch_skip` stays 0.
- R9: If SCL stays low for `POLL_MAX` consecutive clocks of a wait, the wait ends and `stretch_skip` becomes 1. Later waits then take a single clock, so a fully held WRITE lasts `POLL_MAX`−1 clocks longer than an unstretched one.
- R10: `stretch_skip` stays set across commands that contain no wait, such as START, and clears the first time a wait finds SCL high.
- R11: The step length is taken from `bit_div` when a command is accepted. Changes to `bit_div` while `busy` is 1 do not affect the command in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_div | input | DIV_W | Step length in clocks minus one |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Opcode: 1 START, 2 STOP, 3 WRITE, 4 READ |
| cmd_data | input | 8 | Byte to transmit for WRITE |
| cmd_nack | input | 1 | For READ: 1 sends NACK, 0 sends ACK |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| nack | output | 1 | Last WRITE was not acknowledged |
| rd_data | output | 8 | Byte received by the last READ |
| stretch_skip | output | 1 | Sticky flag: stretch waits are bypassed |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_in | input | 1 | Sampled SCL bus level |
| sda_in | input | 1 | Sampled SDA bus level |

## Verification
The completion of one command and the acceptance of the next can fall in the same cycle. Because `done` is raised in the first idle cycle, a command presented then is taken at the next edge. The bench provokes this on every STOP that follows a byte, by driving the STOP in the `done` cycle, and judges it by the exact `busy` length and by the STOP condition count on the modelled bus. In the second case, the expiry of the stretch bound, the setting of the skip flag and the controller pulling SCL low all happen on one edge. This is provoked by holding SCL low through a whole WRITE, and judged by the exact extended duration, the flag value and the NACK that follows.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int BYTE_W    = 8;
    localparam int SLOT_CNT  = BYTE_W + 1;
    localparam int SLOT_W    = $clog2(SLOT_CNT);
    localparam int OP_W      = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NONE  = 3'd0,
        OP_START = 3'd1,
        OP_STOP  = 3'd2,
        OP_WRITE = 3'd3,
        OP_READ  = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_S_REL, PH_S_SDA, PH_S_SCL,
        PH_P_LOW, PH_P_SCL, PH_P_SDA,
        PH_B_LOW, PH_B_REL, PH_B_WAIT, PH_B_END
    } phase_e;

    typedef struct packed {
        logic              is_read;
        logic              want_nack;
        logic [BYTE_W-1:0] shreg;
        logic [SLOT_W-1:0] slot;
    } xfer_t;

    function automatic logic op_known(input logic [OP_W-1:0] op);
        return (op >= OP_START) && (op <= OP_READ);
    endfunction

    // Pull-down request for SDA in a slot: data slots of a write follow the
    // outgoing bit, the acknowledge slot of a read follows the ACK choice.
    function automatic logic slot_pulls_sda(input logic is_read,
                                            input logic ack_slot,
                                            input logic tx_bit,
                                            input logic want_nack);
        if (ack_slot)
            return is_read && !want_nack;
        return !is_read && !tx_bit;
    endfunction

endpackage

// File: rtl/i2cm_phase_timer.sv
module i2cm_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    output logic             expired
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/i2cm_stretch_wait.sv
module i2cm_stretch_wait #(
    parameter int POLL_MAX = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic scl_in,
    output logic go,
    output logic skip
);

    localparam int CNT_W = $clog2(POLL_MAX + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(POLL_MAX - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             skip_q;
    logic             at_limit;

    assign at_limit = (cnt_q == LIMIT);
    assign go       = active && (scl_in || skip_q || at_limit);
    assign skip     = skip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            skip_q <= 1'b0;
        end else begin
            if (!active || go)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;

            if (active && scl_in)
                skip_q <= 1'b0;
            else if (active && at_limit)
                skip_q <= 1'b1;
        end
    end

endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  bit_div,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [BYTE_W-1:0] cmd_data,
    input  logic              cmd_nack,
    input  logic              sda_in,
    input  logic              tmr_expired,
    input  logic              wait_go,
    output logic              tmr_load,
    output logic [DIV_W-1:0]  tmr_val,
    output logic              wait_active,
    output logic              busy,
    output logic              done,
    output logic              nack,
    output logic [BYTE_W-1:0] rd_data,
    output logic              scl_oe,
    output logic              sda_oe
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(BYTE_W);

    phase_e           ph_q, ph_d;
    xfer_t            x_q;
    logic [DIV_W-1:0] div_q;
    logic             scl_q, scl_d, sda_q, sda_d;
    logic             done_q, nack_q, abort_q, ack_q;
    logic             accept, fin, sample, slot_step, abort;
    logic [SLOT_W-1:0] slot_nx;

    assign accept  = (ph_q == PH_IDLE) && cmd_valid && op_known(cmd_op);
    assign slot_nx = x_q.slot + 1'b1;

    always_comb begin
        ph_d      = ph_q;
        scl_d     = scl_q;
        sda_d     = sda_q;
        tmr_load  = 1'b0;
        fin       = 1'b0;
        sample    = 1'b0;
        slot_step = 1'b0;
        abort     = 1'b0;
        unique case (ph_q)
            PH_IDLE: if (accept) begin
                tmr_load = 1'b1;
                if (cmd_op == OP_START) begin
                    ph_d = PH_S_REL; scl_d = 1'b0; sda_d = 1'b0;
                end else if (cmd_op == OP_STOP) begin
                    ph_d = PH_P_LOW; scl_d = 1'b1; sda_d = 1'b1;
                end else begin
                    ph_d  = PH_B_LOW; scl_d = 1'b1;
                    sda_d = slot_pulls_sda(cmd_op == OP_READ, 1'b0,
                                           cmd_data[BYTE_W-1], cmd_nack);
                end
            end
            PH_S_REL: if (tmr_expired) begin
                ph_d = PH_S_SDA; sda_d = 1'b1; tmr_load = 1'b1;
            end
            PH_S_SDA: if (tmr_expired) begin
                ph_d = PH_S_SCL; scl_d = 1'b1; tmr_load = 1'b1;
            end
            PH_P_LOW: if (tmr_expired) begin
                ph_d = PH_P_SCL; scl_d = 1'b0; tmr_load = 1'b1;
            end
            PH_P_SCL: if (tmr_expired) begin
                ph_d = PH_P_SDA; sda_d = 1'b0; tmr_load = 1'b1;
            end
            PH_S_SCL, PH_P_SDA: if (tmr_expired) begin
                ph_d = PH_IDLE; fin = 1'b1;
            end
            PH_B_LOW: if (tmr_expired) begin
                ph_d = PH_B_REL; scl_d = 1'b0; tmr_load = 1'b1;
            end
            PH_B_REL: if (tmr_expired)
                ph_d = PH_B_WAIT;
            PH_B_WAIT: if (wait_go) begin
                ph_d = PH_B_END; scl_d = 1'b1; tmr_load = 1'b1; sample = 1'b1;
            end
            PH_B_END: if (tmr_expired) begin
                if (x_q.slot != LAST_SLOT) begin
                    ph_d      = PH_B_LOW;
                    slot_step = 1'b1;
                    tmr_load  = 1'b1;
                    sda_d     = slot_pulls_sda(x_q.is_read, slot_nx == LAST_SLOT,
                                               x_q.shreg[BYTE_W-1], x_q.want_nack);
                end else if (!x_q.is_read && ack_q) begin
                    ph_d = PH_P_LOW; sda_d = 1'b1; tmr_load = 1'b1; abort = 1'b1;
                end else begin
                    ph_d = PH_IDLE; fin = 1'b1;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            x_q     <= '0;
            div_q   <= '0;
            scl_q   <= 1'b0;
            sda_q   <= 1'b0;
            done_q  <= 1'b0;
            nack_q  <= 1'b0;
            abort_q <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            scl_q  <= scl_d;
            sda_q  <= sda_d;
            done_q <= fin;
            if (accept) begin
                div_q       <= bit_div;
                x_q.is_read <= (cmd_op == OP_READ);
                x_q.want_nack <= cmd_nack;
                x_q.shreg   <= cmd_data;
                x_q.slot    <= '0;
                nack_q      <= 1'b0;
                abort_q     <= 1'b0;
            end
            if (sample) begin
                if (x_q.slot == LAST_SLOT)
                    ack_q <= sda_in;
                else
                    x_q.shreg <= {x_q.shreg[BYTE_W-2:0], sda_in};
            end
            if (slot_step)
                x_q.slot <= slot_nx;
            if (abort)
                abort_q <= 1'b1;
            if (fin)
                nack_q <= abort_q;
        end
    end

    assign tmr_val     = (ph_q == PH_IDLE) ? bit_div : div_q;
    assign wait_active = (ph_q == PH_B_WAIT);
    assign busy        = (ph_q != PH_IDLE);
    assign done        = done_q;
    assign nack        = nack_q;
    assign rd_data     = x_q.shreg;
    assign scl_oe      = scl_q;
    assign sda_oe      = sda_q;

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int POLL_MAX = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  bit_div,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [BYTE_W-1:0] cmd_data,
    input  logic              cmd_nack,
    output logic              busy,
    output logic              done,
    output logic              nack,
    output logic [BYTE_W-1:0] rd_data,
    output logic              stretch_skip,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              scl_in,
    input  logic              sda_in
);

    logic             tmr_load, tmr_expired;
    logic [DIV_W-1:0] tmr_val;
    logic             wait_active, wait_go;

    i2cm_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    i2cm_stretch_wait #(.POLL_MAX(POLL_MAX)) u_stretch (
        .clk    (clk),
        .rst    (rst),
        .active (wait_active),
        .scl_in (scl_in),
        .go     (wait_go),
        .skip   (stretch_skip)
    );

    i2cm_seq #(.DIV_W(DIV_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .bit_div     (bit_div),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_data    (cmd_data),
        .cmd_nack    (cmd_nack),
        .sda_in      (sda_in),
        .tmr_expired (tmr_expired),
        .wait_go     (wait_go),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .wait_active (wait_active),
        .busy        (busy),
        .done        (done),
        .nack        (nack),
        .rd_data     (rd_data),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe)
    );

endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker
    import i2cm_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            cmd_valid,
    input logic [OP_W-1:0] cmd_op,
    input logic            busy,
    input logic            done,
    input logic            nack,
    input logic            scl_oe,
    input logic            sda_oe,
    input logic            scl_in,
    input logic            stretch_skip
);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!busy && !done && !scl_oe && !sda_oe && !stretch_skip));

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && op_known(cmd_op)) |=> busy);

    p_ignore_op_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && !op_known(cmd_op)) |=> !busy);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_nack_released_r6: assert property (@(posedge clk) disable iff (rst)
        (done && nack) |-> (!scl_oe && !sda_oe));

    p_skip_on_low_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(stretch_skip) |-> $past(!scl_in));

endmodule

bind i2c_byte_master i2cm_checker i_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .busy         (busy),
    .done         (done),
    .nack         (nack),
    .scl_oe       (scl_oe),
    .sda_oe       (sda_oe),
    .scl_in       (scl_in),
    .stretch_skip (stretch_skip)
);

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;
    import i2cm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 8;
    localparam int POLL = 1000;
    localparam int D    = 2;
    localparam int T_SS   = 3 * (D + 1);
    localparam int T_BYTE = 9 * (3 * D + 4);

    // {is_read, flag, data}: write flag = target acknowledges,
    // read flag = controller answers NACK
    localparam logic [9:0] VEC [0:5] = '{
        {1'b0, 1'b1, 8'hA5},
        {1'b0, 1'b1, 8'h3C},
        {1'b0, 1'b0, 8'h81},
        {1'b1, 1'b0, 8'h5A},
        {1'b1, 1'b1, 8'hC3},
        {1'b0, 1'b1, 8'hFF}
    };

    logic          clk = 1'b0, rst = 1'b1;
    logic [DW-1:0] bit_div = DW'(D);
    logic          cmd_valid = 1'b0, cmd_nack = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [7:0]    cmd_data = 8'h00;
    logic          busy, done, nack, stretch_skip, scl_oe, sda_oe;
    logic [7:0]    rd_data;
    logic          tgt_hold = 1'b0, stuck_low = 1'b0, tgt_sda_low = 1'b0, tgt_ack = 1'b0;
    logic [7:0]    tgt_byte = 8'h00, mon_sh = 8'h00;
    logic          mon_ack = 1'b0;
    int            tgt_mode = 0, rise_cnt = 0, start_cnt = 0, stop_cnt = 0;
    int            checks = 0, failures = 0;
    logic          scl_bus, sda_bus;

    assign scl_bus = !scl_oe && !tgt_hold && !stuck_low;
    assign sda_bus = !sda_oe && !tgt_sda_low;

    i2c_byte_master #(.DIV_W(DW), .POLL_MAX(POLL)) i_i2c_byte_master (
        .clk(clk), .rst(rst), .bit_div(bit_div), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_nack(cmd_nack),
        .busy(busy), .done(done), .nack(nack), .rd_data(rd_data),
        .stretch_skip(stretch_skip), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .scl_in(scl_bus), .sda_in(sda_bus)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // bus monitor
    always @(posedge scl_bus) begin
        rise_cnt = rise_cnt + 1;
        if (rise_cnt <= 8) mon_sh = {mon_sh[6:0], sda_bus};
        else if (rise_cnt == 9) mon_ack = sda_bus;
    end
    always @(negedge sda_bus) if (scl_bus) start_cnt = start_cnt + 1;
    always @(posedge sda_bus) if (scl_bus) stop_cnt = stop_cnt + 1;

    // target model: changes SDA only after SCL falls
    always @(negedge scl_bus) begin
        if (tgt_mode == 1) begin
            if (rise_cnt == 8) tgt_sda_low = tgt_ack;
            else if (rise_cnt == 9) tgt_sda_low = 1'b0;
        end else if (tgt_mode == 2) begin
            if (rise_cnt >= 1 && rise_cnt <= 7) tgt_sda_low = !tgt_byte[7 - rise_cnt];
            else if (rise_cnt == 8) tgt_sda_low = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [7:0] data,
                         input logic nk, output int cyc, output logic dn);
        @(negedge clk);
        cmd_op = op; cmd_data = data; cmd_nack = nk; cmd_valid = 1'b1;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        cyc = 0;
        while (busy) begin
            @(posedge clk); #1;
            cyc++;
        end
        dn = done;
    endtask

    task automatic arm_write(input logic ack);
        rise_cnt = 0; tgt_mode = 1; tgt_ack = ack; tgt_sda_low = 1'b0;
    endtask

    task automatic arm_read(input logic [7:0] b);
        rise_cnt = 0; tgt_mode = 2; tgt_byte = b; tgt_sda_low = !b[7];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n, s0, p0;
        logic dn;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!scl_oe && !sda_oe, "R1", "lines released", {scl_oe, sda_oe}, 0);
        chk(!busy && !done && !nack, "R1", "status idle", {busy, done, nack}, 0);
        chk(!stretch_skip, "R1", "skip clear", stretch_skip, 0);

        // R2 unknown opcodes ignored
        foreach (VEC[k]) begin end
        for (int op = 0; op < 8; op++) begin
            if (op >= 1 && op <= 4) continue;
            @(negedge clk); cmd_op = 3'(op); cmd_valid = 1'b1;
            @(negedge clk); cmd_valid = 1'b0;
            chk(!busy && !done && !scl_oe && !sda_oe, "R2", "unknown opcode ignored",
                {busy, done, scl_oe, sda_oe}, 0);
        end

        // table walk: START, byte, STOP (explicit or automatic)
        for (int v = 0; v < 6; v++) begin
            logic       is_rd, flag;
            logic [7:0] dat;
            {is_rd, flag, dat} = VEC[v];
            s0 = start_cnt; p0 = stop_cnt;
            issue(OP_START, 8'h00, 1'b0, n, dn);
            chk(n == T_SS, "R3", "START length", n, T_SS);
            chk(start_cnt == s0 + 1, "R3", "START condition", start_cnt - s0, 1);
            if (is_rd) begin
                arm_read(dat);
                issue(OP_READ, 8'h00, flag, n, dn);
                chk(rd_data == dat, "R7", "read byte", rd_data, dat);
                chk(mon_ack == flag, "R7", "ack slot level", mon_ack, flag);
                chk(n == T_BYTE && dn, "R5", "read length/done", n, T_BYTE);
            end else begin
                arm_write(flag);
                issue(OP_WRITE, dat, 1'b0, n, dn);
                chk(mon_sh == dat, "R5", "bus byte MSB first", mon_sh, dat);
                chk(nack == !flag, "R6", "nack flag", nack, !flag);
                chk(n == (flag ? T_BYTE : T_BYTE + T_SS), "R5", "write length",
                    n, flag ? T_BYTE : T_BYTE + T_SS);
                chk(dn, "R5", "done pulse", dn, 1);
            end
            tgt_mode = 0;
            if (is_rd || flag) begin
                issue(OP_STOP, 8'h00, 1'b0, n, dn);   // presented in the done cycle
                chk(n == T_SS, "R4", "STOP length", n, T_SS);
            end
            chk(stop_cnt == p0 + 1, is_rd || flag ? "R4" : "R6", "STOP condition",
                stop_cnt - p0, 1);
            chk(!scl_oe && !sda_oe, "R4", "bus released", {scl_oe, sda_oe}, 0);
        end

        // R6 nack held until next accepted command
        arm_write(1'b0);
        issue(OP_START, 8'h00, 1'b0, n, dn);
        issue(OP_WRITE, 8'h42, 1'b0, n, dn);
        tgt_mode = 0;
        repeat (5) @(negedge clk);
        chk(nack == 1'b1, "R6", "nack held", nack, 1);
        issue(OP_START, 8'h00, 1'b0, n, dn);
        chk(nack == 1'b0, "R6", "nack cleared on accept", nack, 0);
        issue(OP_STOP, 8'h00, 1'b0, n, dn);

        // R2 command while busy ignored
        issue(OP_START, 8'h00, 1'b0, n, dn);
        arm_write(1'b1);
        p0 = stop_cnt;
        fork
            begin
                repeat (10) @(negedge clk);
                cmd_op = OP_STOP; cmd_valid = 1'b1;
                @(negedge clk); cmd_valid = 1'b0;
            end
        join_none
        issue(OP_WRITE, 8'h99, 1'b0, n, dn);
        chk(n == T_BYTE, "R2", "busy command ignored length", n, T_BYTE);
        chk(stop_cnt == p0, "R2", "no stop from ignored command", stop_cnt - p0, 0);
        tgt_mode = 0;
        issue(OP_STOP, 8'h00, 1'b0, n, dn);

        // R12-style register read: repeated START inside a transfer
        s0 = start_cnt; p0 = stop_cnt;
        issue(OP_START, 8'h00, 1'b0, n, dn);
        arm_write(1'b1); issue(OP_WRITE, 8'h90, 1'b0, n, dn);
        arm_write(1'b1); issue(OP_WRITE, 8'h05, 1'b0, n, dn);
        tgt_mode = 0;
        issue(OP_START, 8'h00, 1'b0, n, dn);
        chk(n == T_SS && start_cnt == s0 + 2, "R3", "repeated START",
            start_cnt - s0, 2);
        arm_write(1'b1); issue(OP_WRITE, 8'h91, 1'b0, n, dn);
        chk(mon_sh == 8'h91 && !nack, "R5", "address with read bit", mon_sh, 8'h91);
        arm_read(8'h3C); issue(OP_READ, 8'h00, 1'b1, n, dn);
        chk(rd_data == 8'h3C, "R7", "register value", rd_data, 8'h3C);
        tgt_mode = 0;
        issue(OP_STOP, 8'h00, 1'b0, n, dn);
        chk(stop_cnt == p0 + 1, "R4", "single STOP in register read", stop_cnt - p0, 1);

        // R8 target stretches the first slot
        issue(OP_START, 8'h00, 1'b0, n, dn);
        arm_write(1'b1);
        fork
            begin
                wait (scl_oe == 1'b1); #1 tgt_hold = 1'b1;
                wait (scl_oe == 1'b0);
                repeat (20) @(posedge clk);
                #1 tgt_hold = 1'b0;
            end
        join_none
        issue(OP_WRITE, 8'h66, 1'b0, n, dn);
        chk(n > T_BYTE && n < T_BYTE + POLL - 1, "R8", "stretched length", n, T_BYTE);
        chk(mon_sh == 8'h66 && !stretch_skip, "R8", "byte intact, no skip", mon_sh, 8'h66);
        tgt_mode = 0;
        issue(OP_STOP, 8'h00, 1'b0, n, dn);

        // R9 SCL held low for a whole write
        issue(OP_START, 8'h00, 1'b0, n, dn);
        arm_write(1'b1);
        stuck_low = 1'b1;
        issue(OP_WRITE, 8'h55, 1'b0, n, dn);
        chk(n == T_BYTE + POLL - 1 + T_SS, "R9", "timeout length", n, T_BYTE + POLL - 1 + T_SS);
        chk(stretch_skip == 1'b1, "R9", "skip set", stretch_skip, 1);
        chk(nack == 1'b1, "R9", "no ack while held", nack, 1);
        tgt_mode = 0;
        stuck_low = 1'b0;
        repeat (3) @(negedge clk);

        // R10 skip survives START, clears on next wait with SCL high
        issue(OP_START, 8'h00, 1'b0, n, dn);
        chk(stretch_skip == 1'b1, "R10", "skip kept across START", stretch_skip, 1);
        arm_write(1'b1);
        issue(OP_WRITE, 8'h0F, 1'b0, n, dn);
        chk(stretch_skip == 1'b0, "R10", "skip cleared", stretch_skip, 0);
        chk(n == T_BYTE && mon_sh == 8'h0F, "R10", "normal write after clear", n, T_BYTE);
        tgt_mode = 0;
        issue(OP_STOP, 8'h00, 1'b0, n, dn);

        // R11 step length captured at accept
        bit_div = 8'd3;
        fork
            begin
                repeat (3) @(posedge clk);
                #2 bit_div = 8'd0;
            end
        join_none
        issue(OP_START, 8'h00, 1'b0, n, dn);
        chk(n == 12, "R11", "div change ignored while busy", n, 12);
        issue(OP_STOP, 8'h00, 1'b0, n, dn);
        chk(n == 3, "R11", "new div used at next accept", n, 3);
        issue(OP_START, 8'h00, 1'b0, n, dn);
        arm_write(1'b1);
        issue(OP_WRITE, 8'hC6, 1'b0, n, dn);
        chk(n == 36 && mon_sh == 8'hC6, "R5", "write with zero divider", n, 36);
        tgt_mode = 0;
        issue(OP_STOP, 8'h00, 1'b0, n, dn);
        bit_div = 8'(D);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule